// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the control-register side of exception entry for a small soft processor. When the pipeline decides to take an exception or interrupt, it pulses `take` for one cycle. In that cycle it also presents a 5-bit cause code, the PC of the faulting instruction and the current status, TLB-control and exception-cause register values. On the same rising edge the block writes the new status, the saved copies of status and return address, the cause register and the TLB-control register. During the strobe cycle itself it also gives a redirect target for the fetch unit.

Two targets exist, and both are fixed by parameters. The fast vector serves a first TLB miss. The general vector serves everything else, including a TLB miss that occurs while the handler is already running. Breaks save into their own status and return-address pair, so a debugger does not destroy the state an ordinary handler needs. Decoding instructions and looking up the TLB happen outside this block.

Bit layout used throughout:
- Status: PIE is bit 0, user mode is bit 1, the exception-handler flag (EH) is bit 2 and the interrupt-handler flag (IH) is bit 3.
- TLB control: the double-miss flag is bit 0 and the write-enable flag (WR) is bit 1.

Top module: `excEntry`

## Requirements
- R1: On every accepted exception, `statusOut` becomes `statusIn` with bit 0 (PIE) and bit 1 (user) cleared. Bit 3 (IH) is set for cause 1 (interrupt) and bit 2 (EH) for every other cause. Except on cause 2, `tlbmiscOut` takes `tlbmiscIn` unchanged.
- R2: On every accepted exception, `excOut` equals `excIn` with bits [6:2] replaced by the cause code and all other bits kept.
- R3: For cause 1 (interrupt) with `statusIn` bit 0 set, `estatusOut` gets `statusIn`, `eaOut` gets `pcIn`+4 and the target is the general vector. If bit 0 is clear, the strobe is ignored: there is no redirect, no error and every register holds.
- R4: For cause 2 (TLB miss) with `statusIn` bit 2 clear, the block saves `estatusOut`=`statusIn` and `eaOut`=`pcIn`+4. It clears `tlbmiscIn` bit 0 (double miss), sets bit 1 (WR) and targets the fast vector.
- R5: For cause 2 with `statusIn` bit 2 set, `estatusOut` and `eaOut` hold. `tlbmiscOut` becomes `tlbmiscIn` with bit 0 set, and the target is the general vector.
- R6: For causes 3, 4 and 5 (TLB read, write and execute permission faults), `estatusOut` and `eaOut` are always saved and the target is the general vector.
- R7: For causes 6, 7 and 8 (supervisor-only faults), 9 (illegal instruction) and 10 (trap), `estatusOut` and `eaOut` are saved only when `statusIn` bit 2 is clear. The target is always the general vector.
- R8: For cause 11 (break), `bstatusOut`=`statusIn` and `baOut`=`pcIn`+4 are saved only when `statusIn` bit 2 is clear. `estatusOut` and `eaOut` are never touched, and the target is the general vector.
- R9: A strobe with a cause outside 1 to 11 raises `causeErr` in that cycle. It gives no redirect and leaves every register unchanged.
- R10: `redirectValid` is high only in the strobe cycle of an accepted exception. Without the strobe, `redirectValid` and `causeErr` stay low and all registers hold whatever the other inputs do.
- R11: After reset all register outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| take | input | 1 | One-cycle strobe: take an exception now |
| cause | input | 5 | Exception cause code |
| pcIn | input | 32 | PC of the instruction being excepted |
| statusIn | input | 32 | Current status register |
| tlbmiscIn | input | 32 | Current TLB-control register |
| excIn | input | 32 | Current exception-cause register |
| statusOut | output | 32 | Status after entry |
| estatusOut | output | 32 | Saved status for exceptions |
| bstatusOut | output | 32 | Saved status for breaks |
| excOut | output | 32 | Exception-cause register |
| eaOut | output | 32 | Exception return address |
| baOut | output | 32 | Break return address |
| tlbmiscOut | output | 32 | TLB-control register after entry |
| redirectValid | output | 1 | Redirect target valid (strobe cycle only) |
| redirectPc | output | 32 | Handler entry address |
| causeErr | output | 1 | Strobe carried an unknown cause |

## Verification
`redirectValid`, `redirectPc` and `causeErr` are combinational, so they are due in the strobe cycle itself. The bench samples them one time step after it drives the inputs at the falling edge. Every register output is due one edge later. The bench's reference model updates its own copies on that rising edge and compares them at the next falling edge, before new stimulus is applied. Because each register is compared on every cycle, a stimulus that should change nothing (PIE-blocked interrupt, unknown cause, idle cycle) is checked by finding the same values one cycle later.

// File: rtl/excPkg.sv
package excPkg;
  localparam int STAT_PIE = 0;
  localparam int STAT_U   = 1;
  localparam int STAT_EH  = 2;
  localparam int STAT_IH  = 3;
  localparam int TLB_DBL  = 0;
  localparam int TLB_WR   = 1;
  localparam int CAUSE_W  = 5;
  localparam int CAUSE_LSB = 2;

  typedef enum logic [CAUSE_W-1:0] {
    C_IRQ     = 5'd1,
    C_TLBMISS = 5'd2,
    C_TLBRD   = 5'd3,
    C_TLBWR   = 5'd4,
    C_TLBEX   = 5'd5,
    C_SUPADDR = 5'd6,
    C_SUPINSN = 5'd7,
    C_SUPDATA = 5'd8,
    C_ILLEGAL = 5'd9,
    C_TRAP    = 5'd10,
    C_BREAK   = 5'd11
  } causeE;

  typedef struct packed {
    logic go;
    logic useIh;
    logic saveExc;
    logic saveBrk;
    logic setDbl;
    logic clrDbl;
    logic setWr;
    logic fastVec;
    logic err;
  } strobeT;
endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
(
  input  logic               take,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               ehIn,
  input  logic               pieIn,
  output strobeT             strb
);
  always_comb begin
    strb = '0;
    if (take) begin
      case (cause)
        C_IRQ: begin
          if (pieIn) begin
            strb.go      = 1'b1;
            strb.useIh   = 1'b1;
            strb.saveExc = 1'b1;
          end
        end
        C_TLBMISS: begin
          strb.go = 1'b1;
          if (!ehIn) begin
            strb.saveExc = 1'b1;
            strb.clrDbl  = 1'b1;
            strb.setWr   = 1'b1;
            strb.fastVec = 1'b1;
          end else begin
            strb.setDbl = 1'b1;
          end
        end
        C_TLBRD, C_TLBWR, C_TLBEX: begin
          strb.go      = 1'b1;
          strb.saveExc = 1'b1;
        end
        C_SUPADDR, C_SUPINSN, C_SUPDATA, C_ILLEGAL, C_TRAP: begin
          strb.go      = 1'b1;
          strb.saveExc = !ehIn;
        end
        C_BREAK: begin
          strb.go      = 1'b1;
          strb.saveBrk = !ehIn;
        end
        default: strb.err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] GEN_VEC  = 32'h0000_0020,
  parameter logic [DATA_W-1:0] FAST_VEC = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [DATA_W-1:0]  pcIn,
  input  logic [DATA_W-1:0]  statusIn,
  input  logic [DATA_W-1:0]  tlbmiscIn,
  input  logic [DATA_W-1:0]  excIn,
  output logic [DATA_W-1:0]  statusOut,
  output logic [DATA_W-1:0]  estatusOut,
  output logic [DATA_W-1:0]  bstatusOut,
  output logic [DATA_W-1:0]  excOut,
  output logic [DATA_W-1:0]  eaOut,
  output logic [DATA_W-1:0]  baOut,
  output logic [DATA_W-1:0]  tlbmiscOut,
  output logic [DATA_W-1:0]  redirectPc
);
  localparam logic [DATA_W-1:0] INSN_BYTES = DATA_W'(4);

  logic [DATA_W-1:0] statusNext, excNext, tlbNext, retAddr;

  always_comb begin
    statusNext = statusIn;
    if (strb.useIh) statusNext[STAT_IH] = 1'b1;
    else            statusNext[STAT_EH] = 1'b1;
    statusNext[STAT_PIE] = 1'b0;
    statusNext[STAT_U]   = 1'b0;

    excNext = excIn;
    excNext[CAUSE_LSB +: CAUSE_W] = cause;

    tlbNext = tlbmiscIn;
    if (strb.clrDbl) tlbNext[TLB_DBL] = 1'b0;
    if (strb.setDbl) tlbNext[TLB_DBL] = 1'b1;
    if (strb.setWr)  tlbNext[TLB_WR]  = 1'b1;

    retAddr    = pcIn + INSN_BYTES;
    redirectPc = strb.fastVec ? FAST_VEC : GEN_VEC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusOut  <= '0;
      excOut     <= '0;
      tlbmiscOut <= '0;
    end else if (strb.go) begin
      statusOut  <= statusNext;
      excOut     <= excNext;
      tlbmiscOut <= tlbNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      estatusOut <= '0;
      eaOut      <= '0;
    end else if (strb.go && strb.saveExc) begin
      estatusOut <= statusIn;
      eaOut      <= retAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bstatusOut <= '0;
      baOut      <= '0;
    end else if (strb.go && strb.saveBrk) begin
      bstatusOut <= statusIn;
      baOut      <= retAddr;
    end
  end
endmodule

// File: rtl/excEntry.sv
module excEntry
  import excPkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] GEN_VEC  = 32'h0000_0020,
  parameter logic [DATA_W-1:0] FAST_VEC = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               take,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [DATA_W-1:0]  pcIn,
  input  logic [DATA_W-1:0]  statusIn,
  input  logic [DATA_W-1:0]  tlbmiscIn,
  input  logic [DATA_W-1:0]  excIn,
  output logic [DATA_W-1:0]  statusOut,
  output logic [DATA_W-1:0]  estatusOut,
  output logic [DATA_W-1:0]  bstatusOut,
  output logic [DATA_W-1:0]  excOut,
  output logic [DATA_W-1:0]  eaOut,
  output logic [DATA_W-1:0]  baOut,
  output logic [DATA_W-1:0]  tlbmiscOut,
  output logic               redirectValid,
  output logic [DATA_W-1:0]  redirectPc,
  output logic               causeErr
);
  strobeT strb;

  excCtrl uCtrl (
    .take  (take),
    .cause (cause),
    .ehIn  (statusIn[STAT_EH]),
    .pieIn (statusIn[STAT_PIE]),
    .strb  (strb)
  );

  excDatapath #(
    .DATA_W   (DATA_W),
    .GEN_VEC  (GEN_VEC),
    .FAST_VEC (FAST_VEC)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cause      (cause),
    .pcIn       (pcIn),
    .statusIn   (statusIn),
    .tlbmiscIn  (tlbmiscIn),
    .excIn      (excIn),
    .statusOut  (statusOut),
    .estatusOut (estatusOut),
    .bstatusOut (bstatusOut),
    .excOut     (excOut),
    .eaOut      (eaOut),
    .baOut      (baOut),
    .tlbmiscOut (tlbmiscOut),
    .redirectPc (redirectPc)
  );

  assign redirectValid = strb.go;
  assign causeErr      = strb.err;
endmodule

// File: rtl/excEntryChk.sv
module excEntryChk
  import excPkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] GEN_VEC  = 32'h0000_0020,
  parameter logic [DATA_W-1:0] FAST_VEC = 32'h0000_0100
) (
  input logic               clk,
  input logic               rstN,
  input logic               take,
  input logic [CAUSE_W-1:0] cause,
  input logic [DATA_W-1:0]  pcIn,
  input logic [DATA_W-1:0]  statusIn,
  input logic [DATA_W-1:0]  tlbmiscIn,
  input logic [DATA_W-1:0]  excIn,
  input logic [DATA_W-1:0]  statusOut,
  input logic [DATA_W-1:0]  estatusOut,
  input logic [DATA_W-1:0]  bstatusOut,
  input logic [DATA_W-1:0]  excOut,
  input logic [DATA_W-1:0]  eaOut,
  input logic [DATA_W-1:0]  baOut,
  input logic [DATA_W-1:0]  tlbmiscOut,
  input logic               redirectValid,
  input logic [DATA_W-1:0]  redirectPc,
  input logic               causeErr
);
  assert_entry_flags_R1: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !statusOut[STAT_PIE] && !statusOut[STAT_U]
                      && (statusOut[STAT_EH] || statusOut[STAT_IH]));

  assert_cause_field_R2: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> excOut[CAUSE_LSB +: CAUSE_W] == $past(cause));

  assert_fast_vector_R4: assert property (@(posedge clk) disable iff (!rstN)
    (take && cause == C_TLBMISS && !statusIn[STAT_EH]) |-> redirectValid && redirectPc == FAST_VEC);

  assert_double_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (take && cause == C_TLBMISS && statusIn[STAT_EH])
      |=> $stable(estatusOut) && $stable(eaOut) && tlbmiscOut[TLB_DBL]);

  assert_break_ret_R8: assert property (@(posedge clk) disable iff (!rstN)
    (take && cause == C_BREAK && !statusIn[STAT_EH])
      |=> baOut == $past(pcIn) + DATA_W'(4) && $stable(eaOut));

  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    causeErr |=> $stable(statusOut) && $stable(excOut) && $stable(tlbmiscOut)
                 && $stable(bstatusOut) && $stable(baOut) && $stable(estatusOut));

  assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(causeErr && redirectValid));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !take |-> !redirectValid && !causeErr);

  assert_gen_vector_R6: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && redirectPc != GEN_VEC) |-> cause == C_TLBMISS && tlbmiscIn == tlbmiscIn);
endmodule

bind excEntry excEntryChk #(
  .DATA_W (DATA_W), .GEN_VEC (GEN_VEC), .FAST_VEC (FAST_VEC)
) uChk (
  .clk (clk), .rstN (rstN), .take (take), .cause (cause), .pcIn (pcIn),
  .statusIn (statusIn), .tlbmiscIn (tlbmiscIn), .excIn (excIn),
  .statusOut (statusOut), .estatusOut (estatusOut), .bstatusOut (bstatusOut),
  .excOut (excOut), .eaOut (eaOut), .baOut (baOut), .tlbmiscOut (tlbmiscOut),
  .redirectValid (redirectValid), .redirectPc (redirectPc), .causeErr (causeErr)
);

// File: tb/tb_excEntry.sv
module tb_excEntry;
  localparam logic [31:0] GEN  = 32'h1000_0020;
  localparam logic [31:0] FAST = 32'h1000_0180;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        take = 1'b0;
  logic [4:0]  cause = '0;
  logic [31:0] pcIn = '0, statusIn = '0, tlbmiscIn = '0, excIn = '0;
  logic [31:0] statusOut, estatusOut, bstatusOut, excOut, eaOut, baOut, tlbmiscOut, redirectPc;
  logic        redirectValid, causeErr;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curTag = "R11";
  string prevTag = "R11";

  logic [31:0] mStatus = '0, mEst = '0, mBst = '0, mExc = '0, mEa = '0, mBa = '0, mTlb = '0;

  always #5 clk = ~clk;

  excEntry #(.DATA_W(32), .GEN_VEC(GEN), .FAST_VEC(FAST)) dut (
    .clk(clk), .rstN(rstN), .take(take), .cause(cause), .pcIn(pcIn),
    .statusIn(statusIn), .tlbmiscIn(tlbmiscIn), .excIn(excIn),
    .statusOut(statusOut), .estatusOut(estatusOut), .bstatusOut(bstatusOut),
    .excOut(excOut), .eaOut(eaOut), .baOut(baOut), .tlbmiscOut(tlbmiscOut),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .causeErr(causeErr)
  );

  function automatic bit knownCause(input logic [4:0] c);
    return c >= 5'd1 && c <= 5'd11;
  endfunction

  function automatic bit accepted();
    return take && knownCause(cause) && !(cause == 5'd1 && !statusIn[0]);
  endfunction

  // Reference model: register state advances on the rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mStatus = '0; mEst = '0; mBst = '0; mExc = '0; mEa = '0; mBa = '0; mTlb = '0;
    end else if (accepted()) begin
      automatic logic [31:0] s = statusIn;
      automatic bit eh = statusIn[2];
      if (cause == 5'd1) s[3] = 1'b1; else s[2] = 1'b1;
      s[1:0] = 2'b00;
      mStatus = s;
      mExc = excIn;
      mExc[6:2] = cause;
      mTlb = tlbmiscIn;
      if (cause == 5'd1 || (cause >= 5'd3 && cause <= 5'd5) ||
          (cause >= 5'd6 && cause <= 5'd10 && !eh) || (cause == 5'd2 && !eh)) begin
        mEst = statusIn;
        mEa  = pcIn + 32'd4;
      end
      if (cause == 5'd2) begin
        if (eh) mTlb[0] = 1'b1;
        else begin mTlb[0] = 1'b0; mTlb[1] = 1'b1; end
      end
      if (cause == 5'd11 && !eh) begin
        mBst = statusIn;
        mBa  = pcIn + 32'd4;
      end
    end
  end

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    cmp(tag, "statusOut", statusOut, mStatus);
    cmp(tag, "estatusOut", estatusOut, mEst);
    cmp(tag, "bstatusOut", bstatusOut, mBst);
    cmp(tag, "excOut", excOut, mExc);
    cmp(tag, "eaOut", eaOut, mEa);
    cmp(tag, "baOut", baOut, mBa);
    cmp(tag, "tlbmiscOut", tlbmiscOut, mTlb);
  endtask

  task automatic checkComb(input string tag);
    automatic bit expV = accepted();
    automatic bit expE = take && !knownCause(cause);
    cmp(tag, "redirectValid", {31'd0, redirectValid}, {31'd0, expV});
    cmp(tag, "causeErr", {31'd0, causeErr}, {31'd0, expE});
    if (expV)
      cmp(tag, "redirectPc", redirectPc,
          (cause == 5'd2 && !statusIn[2]) ? FAST : GEN);
  endtask

  task automatic step(input string tag, input logic t, input logic [4:0] c,
                      input logic [31:0] pc, input logic [31:0] st,
                      input logic [31:0] tl, input logic [31:0] ex);
    @(negedge clk);
    checkRegs(prevTag);
    take = t; cause = c; pcIn = pc; statusIn = st; tlbmiscIn = tl; excIn = ex;
    #1;
    checkComb(tag);
    prevTag = tag;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: registers zero after reset
    step("R11", 0, 5'd0, 32'h0, 32'h0, 32'h0, 32'h0);
    // R3: interrupt with PIE set, and blocked with PIE clear
    step("R3", 1, 5'd1, 32'h0000_4000, 32'h0000_0003, 32'h0000_00F0, 32'h0);
    step("R3", 1, 5'd1, 32'h0000_5000, 32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFFF);
    // R4: fast miss (double bit previously set, must clear)
    step("R4", 1, 5'd2, 32'h0000_6000, 32'h0000_0001, 32'h0000_0001, 32'h0);
    // R5: double miss keeps saved state
    step("R5", 1, 5'd2, 32'h0000_7000, 32'h0000_0005, 32'h0000_0010, 32'h0);
    // R6: permission faults, EH set and clear
    step("R6", 1, 5'd3, 32'h0000_8000, 32'h0000_0004, 32'h0, 32'h0);
    step("R6", 1, 5'd4, 32'h0000_8100, 32'h0000_0001, 32'h0, 32'h0);
    step("R6", 1, 5'd5, 32'h0000_8200, 32'h0000_0006, 32'h0, 32'h0);
    // R7: supervisor / illegal / trap, EH clear then set
    step("R7", 1, 5'd6, 32'h0000_9000, 32'h0000_0003, 32'h0, 32'h0);
    step("R7", 1, 5'd7, 32'h0000_9100, 32'h0000_0004, 32'h0, 32'h0);
    step("R7", 1, 5'd8, 32'h0000_9200, 32'h0000_0001, 32'h0, 32'h0);
    step("R7", 1, 5'd9, 32'h0000_9300, 32'h0000_0007, 32'h0, 32'h0);
    step("R7", 1, 5'd10, 32'h0000_9400, 32'h0000_0000, 32'h0, 32'h0);
    // R8: break, EH clear then set
    step("R8", 1, 5'd11, 32'h0000_A000, 32'h0000_0001, 32'h0, 32'h0);
    step("R8", 1, 5'd11, 32'h0000_A100, 32'h0000_0004, 32'h0, 32'h0);
    // R2: other cause-register bits preserved
    step("R2", 1, 5'd10, 32'h0000_B000, 32'h0, 32'h0, 32'hFFFF_FFFF);
    step("R2", 1, 5'd3, 32'h0000_B100, 32'h0, 32'h0, 32'hA5A5_A5A5);
    // R1: IH vs EH, tlbmisc pass-through on non-miss causes
    step("R1", 1, 5'd1, 32'hFFFF_FFF0, 32'hFFFF_FFF1, 32'hDEAD_BEEF, 32'h0);
    step("R1", 1, 5'd9, 32'h0000_C000, 32'h1234_5673, 32'hCAFE_F00D, 32'h0);
    // R9: unknown causes
    step("R9", 1, 5'd0, 32'h0000_D000, 32'h1, 32'h3, 32'h7);
    step("R9", 1, 5'd12, 32'h0000_D100, 32'h1, 32'h3, 32'h7);
    step("R9", 1, 5'd31, 32'h0000_D200, 32'h1, 32'h3, 32'h7);
    // R10: idle cycles with changing inputs
    step("R10", 0, 5'd2, 32'h0000_E000, 32'h1, 32'h0, 32'h0);
    step("R10", 0, 5'd11, 32'h0000_E100, 32'h0, 32'hF, 32'hF);
    // mixed sweep
    for (int i = 0; i < 300; i++) begin
      step("R10", 1'($urandom_range(0, 3) != 0), 5'($urandom_range(0, 13)),
           $urandom, $urandom, $urandom, $urandom);
    end
    step("R10", 0, 5'd0, 32'h0, 32'h0, 32'h0, 32'h0);
    @(negedge clk);
    checkRegs(prevTag);
    finishRun();
  end
endmodule